// File: doc/BRIEF.md
# Byte Shuffle Execution Unit

This execute-stage unit for a 64-bit datapath performs two kinds of byte-oriented rearrangement on register operands. The first mirrors the bit order inside every byte while leaving each byte in its own lane. The second joins two source operands at a byte boundary, taking the upper part of the result from one operand and filling the vacated low bytes from the top of the other. Each kind comes in a word (32-bit, sign-extended) and a doubleword (64-bit) form.

The unit receives an already-decoded operation code, a byte-position field and the two operands `rs` and `rt`. A strobe on `in_vld` launches one operation. The result, together with a valid or illegal flag, appears registered on the following cycle, ready to be written to the destination register. Operation codes: 0 = word bit mirror, 1 = doubleword bit mirror, 2 = word align, 3 = doubleword align, 4 to 7 = unsupported.

Top module: `bsu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld`, `out_ill` and `out_data` are all zero after that edge.
- R2: Op 0 takes `in_rt[31:0]` and reverses the bit order inside each of its four bytes, keeping byte lanes. The 32-bit value is sign-extended from bit 31. `in_bpos` and `in_rs` have no effect.
- R3: Op 1 reverses the bits inside each of the eight bytes of `in_rt`, keeping byte lanes, with no extension. `in_bpos` and `in_rs` have no effect.
- R4: Op 2 with a nonzero byte position p = `in_bpos[1:0]` yields the 32-bit value (rt[31:0] << 8p) | (rs[31:0] >> 8(4-p)), where the right shift is logical, sign-extended from bit 31. `in_bpos[2]` is ignored.
- R5: Op 2 with `in_bpos[1:0]` = 0 yields `in_rt[31:0]` sign-extended to 64 bits.
- R6: Op 3 with a nonzero byte position p = `in_bpos` yields (rt << 8p) | (rs >> 8(8-p)) over 64 bits, where the right shift is logical.
- R7: Op 3 with `in_bpos` = 0 yields `in_rt` unchanged.
- R8: A strobe with a legal op (0 to 3) gives `out_vld` high and the result on `out_data` exactly one cycle later. A cycle without a strobe gives `out_vld` and `out_ill` low on the next cycle.
- R9: A strobe with an op of 4 to 7 gives `out_ill` high and `out_vld` low one cycle later, and `out_data` keeps its previous value.
- R10: `out_data` changes only on the cycle after a legal strobe. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| in_op | input | 3 | Decoded operation code |
| in_bpos | input | 3 | Byte-position field for the align ops |
| in_rs | input | 64 | First source operand (low fill for align) |
| in_rt | input | 64 | Second source operand |
| out_vld | output | 1 | Result valid, one cycle after a legal strobe |
| out_ill | output | 1 | Unsupported operation flag |
| out_data | output | 64 | Result for the destination register |

## Verification
The bit mirror is driven with a one-hot-per-byte walking pattern, with a single bit in the top bit of a byte, and with a pattern whose mirrored byte lands in bit 31. Together these separate a true per-byte mirror from a whole-word reversal or a byte swap, and they show whether the sign is extended. The aligns cover every byte position in both widths, including zero, the extreme positions, and a position whose high bit must be ignored in the word form. Operands with set top bits expose an arithmetic shift used where a logical one is required and a missing sign extension. Illegal codes, idle cycles and a noisy `in_rs` or `in_bpos` on the mirror ops confirm that the result register holds and that the unused inputs are ignored.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    localparam int XLEN     = 64;
    localparam int BYTE_W   = 8;
    localparam int NBYTE    = XLEN / BYTE_W;
    localparam int HALF_W   = XLEN / 2;
    localparam int HBYTE    = NBYTE / 2;
    localparam int BPOS_W   = $clog2(NBYTE);
    localparam int HBPOS_W  = $clog2(HBYTE);
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MIRROR_W = 3'd0,
        OP_MIRROR_D = 3'd1,
        OP_JOIN_W   = 3'd2,
        OP_JOIN_D   = 3'd3
    } op_e;

    typedef struct packed {
        logic            vld;
        logic            ill;
        logic [XLEN-1:0] data;
    } rsp_t;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return (op == OP_MIRROR_W) || (op == OP_MIRROR_D) ||
               (op == OP_JOIN_W)   || (op == OP_JOIN_D);
    endfunction

    function automatic logic [XLEN-1:0] sext_half(input logic [HALF_W-1:0] v);
        return {{(XLEN-HALF_W){v[HALF_W-1]}}, v};
    endfunction

endpackage

// File: rtl/bsu_mirror.sv
module bsu_mirror #(
    parameter int NB = 8,
    parameter int BW = 8
) (
    input  logic [NB*BW-1:0] din,
    output logic [NB*BW-1:0] dout
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        for (genvar k = 0; k < BW; k++) begin : g_bit
            assign dout[g*BW + k] = din[g*BW + (BW-1-k)];
        end
    end
endmodule

// File: rtl/bsu_funnel.sv
module bsu_funnel #(
    parameter int W   = 64,
    parameter int BPW = 3
) (
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [BPW-1:0] bp,
    output logic [W-1:0]   dout
);
    localparam int SHW = BPW + 3;

    logic [2*W-1:0] joined;
    logic [2*W-1:0] shifted;
    logic [SHW-1:0] amt;

    assign amt     = {bp, 3'b000};
    assign joined  = {hi, lo};
    assign shifted = joined << amt;
    assign dout    = shifted[2*W-1:W];
endmodule

// File: rtl/bsu_top.sv
module bsu_top
    import bsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [OP_W-1:0]     in_op,
    input  logic [BPOS_W-1:0]   in_bpos,
    input  logic [XLEN-1:0]     in_rs,
    input  logic [XLEN-1:0]     in_rt,
    output logic                out_vld,
    output logic                out_ill,
    output logic [XLEN-1:0]     out_data
);
    logic [XLEN-1:0]   mirror_d;
    logic [HALF_W-1:0] join_w;
    logic [XLEN-1:0]   join_d;
    logic [XLEN-1:0]   result;
    logic              legal;
    rsp_t              rsp_q;

    bsu_mirror #(.NB(NBYTE), .BW(BYTE_W)) u_mirror (
        .din  (in_rt),
        .dout (mirror_d)
    );

    bsu_funnel #(.W(HALF_W), .BPW(HBPOS_W)) u_join_w (
        .hi   (in_rt[HALF_W-1:0]),
        .lo   (in_rs[HALF_W-1:0]),
        .bp   (in_bpos[HBPOS_W-1:0]),
        .dout (join_w)
    );

    bsu_funnel #(.W(XLEN), .BPW(BPOS_W)) u_join_d (
        .hi   (in_rt),
        .lo   (in_rs),
        .bp   (in_bpos),
        .dout (join_d)
    );

    assign legal = op_legal(in_op);

    always_comb begin
        case (in_op)
            OP_MIRROR_W: result = sext_half(mirror_d[HALF_W-1:0]);
            OP_MIRROR_D: result = mirror_d;
            OP_JOIN_W:   result = sext_half(join_w);
            OP_JOIN_D:   result = join_d;
            default:     result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.vld <= in_vld && legal;
            rsp_q.ill <= in_vld && !legal;
            if (in_vld && legal) begin
                rsp_q.data <= result;
            end
        end
    end

    assign out_vld  = rsp_q.vld;
    assign out_ill  = rsp_q.ill;
    assign out_data = rsp_q.data;
endmodule

// File: rtl/bsu_chk.sv
module bsu_chk
    import bsu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_vld,
    input logic [OP_W-1:0]     in_op,
    input logic [BPOS_W-1:0]   in_bpos,
    input logic [XLEN-1:0]     in_rs,
    input logic [XLEN-1:0]     in_rt,
    input logic                out_vld,
    input logic                out_ill,
    input logic [XLEN-1:0]     out_data
);
    logic good_op;
    logic half_op;
    assign good_op = in_op <= 3'd3;
    assign half_op = (in_op == 3'd0) || (in_op == 3'd2);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_vld && !out_ill && out_data == '0));  // R1

    AST_HALF_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_vld && half_op) |=> (out_data[63:32] == {32{out_data[31]}}));  // R2

    AST_JOIN_D_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == 3'd3 && in_bpos == '0) |=> (out_data == $past(in_rt)));  // R7

    AST_LEGAL_VALID: assert property (@(posedge clk) disable iff (rst)
        (in_vld && good_op) |=> (out_vld && !out_ill));  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && !out_ill));  // R8

    AST_BAD_OP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !good_op) |=> (out_ill && !out_vld));  // R9

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(in_vld && good_op) |=> $stable(out_data));  // R10
endmodule

bind bsu_top bsu_chk u_chk (.*);

// File: tb/bsu_top_test.sv
module bsu_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [2:0]  in_op;
    logic [2:0]  in_bpos;
    logic [63:0] in_rs;
    logic [63:0] in_rt;
    logic        out_vld;
    logic        out_ill;
    logic [63:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bsu_top uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_bpos(in_bpos),
        .in_rs(in_rs), .in_rt(in_rt), .out_vld(out_vld), .out_ill(out_ill),
        .out_data(out_data)
    );

    localparam int NV = 12;
    localparam logic [2:0] TV_OP [NV] = '{3'd1, 3'd0, 3'd0, 3'd2, 3'd2, 3'd2,
                                          3'd2, 3'd3, 3'd3, 3'd3, 3'd3, 3'd1};
    localparam logic [2:0] TV_BP [NV] = '{3'd0, 3'd5, 3'd2, 3'd0, 3'd1, 3'd3,
                                          3'd6, 3'd0, 3'd1, 3'd7, 3'd4, 3'd3};
    localparam logic [63:0] TV_RS [NV] = '{
        64'h0,                   64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0,
        64'hDEAD_BEEF_DEAD_BEEF, 64'h5555_5555_AABB_CCDD, 64'h0000_0000_CAFE_BABE,
        64'hFFFF_FFFF_F0E1_D2C3, 64'h9999_9999_9999_9999, 64'h8877_6655_4433_2211,
        64'hF0E1_D2C3_B4A5_9687, 64'h8000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000};
    localparam logic [63:0] TV_RT [NV] = '{
        64'h0102_0408_1020_4080, 64'h0000_0000_0000_0080, 64'hAAAA_AAAA_0100_0000,
        64'h0000_0000_8123_4567, 64'hFFFF_FFFF_1122_3344, 64'h0000_0000_9988_7766,
        64'h0000_0000_0102_0304, 64'hFEDC_BA98_7654_3210, 64'h0011_2233_4455_6677,
        64'h0123_4567_89AB_CDEF, 64'h7FFF_FFFF_1234_5678, 64'hC000_0000_0000_0003};
    localparam string TV_REQ [NV] = '{"R3", "R2", "R2", "R5", "R4", "R4",
                                      "R4", "R7", "R6", "R6", "R6", "R3"};

    function automatic logic [63:0] mirror_ref(input logic [63:0] x);
        logic [63:0] r;
        for (int b = 0; b < 8; b++)
            for (int i = 0; i < 8; i++)
                r[8*b + i] = x[8*b + 7 - i];
        return r;
    endfunction

    function automatic logic [63:0] expect_of(input logic [2:0] op, input logic [2:0] bp,
                                              input logic [63:0] rs, input logic [63:0] rt);
        logic [63:0] m;
        logic [31:0] w;
        int p;
        case (op)
            3'd0: begin m = mirror_ref(rt); w = m[31:0]; return {{32{w[31]}}, w}; end
            3'd1: return mirror_ref(rt);
            3'd2: begin
                p = int'(bp[1:0]);
                if (p == 0) w = rt[31:0];
                else w = (rt[31:0] << (8*p)) | (rs[31:0] >> (8*(4-p)));
                return {{32{w[31]}}, w};
            end
            default: begin
                p = int'(bp);
                if (p == 0) return rt;
                return (rt << (8*p)) | (rs >> (8*(8-p)));
            end
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] op, input logic [2:0] bp,
                         input logic [63:0] rs, input logic [63:0] rt);
        @(negedge clk);
        in_vld = v; in_op = op; in_bpos = bp; in_rs = rs; in_rt = rt;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; in_vld = 1'b0; in_op = '0; in_bpos = '0; in_rs = '0; in_rt = '0;
        repeat (3) @(negedge clk);
        check("R1", "reset vld", {63'd0, out_vld}, 64'd0);
        check("R1", "reset ill", {63'd0, out_ill}, 64'd0);
        check("R1", "reset data", out_data, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, TV_OP[i], TV_BP[i], TV_RS[i], TV_RT[i]);
            check("R8", "valid after strobe", {63'd0, out_vld}, 64'd1);
            check(TV_REQ[i], "result", out_data,
                  expect_of(TV_OP[i], TV_BP[i], TV_RS[i], TV_RT[i]));
        end

        // R3 hand value: per-byte mirror of a walking pattern
        issue(1'b1, 3'd1, 3'd0, 64'd0, 64'h0102_0408_1020_4080);
        check("R3", "walking mirror", out_data, 64'h8040_2010_0804_0201);
        // R5 hand value: negative word with zero position
        issue(1'b1, 3'd2, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8123_4567);
        check("R5", "bpos[2] ignored at zero", out_data, 64'hFFFF_FFFF_8123_4567);
        // R4 hand value
        issue(1'b1, 3'd2, 3'd1, 64'h0000_0000_AABB_CCDD, 64'h0000_0000_1122_3344);
        check("R4", "word join p=1", out_data, 64'h0000_0000_2233_44AA);
        // R6 hand value: logical shift of rs
        issue(1'b1, 3'd3, 3'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000);
        check("R6", "logical fill", out_data, 64'h0000_0000_0000_0080);

        // R9: illegal op flags and holds data
        held = out_data;
        issue(1'b1, 3'd5, 3'd2, 64'h1, 64'h2);
        check("R9", "ill flag", {63'd0, out_ill}, 64'd1);
        check("R9", "vld low", {63'd0, out_vld}, 64'd0);
        check("R9", "data held", out_data, held);
        issue(1'b1, 3'd7, 3'd0, 64'h3, 64'h4);
        check("R9", "ill flag op7", {63'd0, out_ill}, 64'd1);

        // R8 / R10: idle cycle
        issue(1'b0, 3'd1, 3'd0, 64'h5, 64'h6);
        check("R8", "idle vld", {63'd0, out_vld}, 64'd0);
        check("R8", "idle ill", {63'd0, out_ill}, 64'd0);
        check("R10", "idle hold", out_data, held);

        // R2: rs and bpos have no effect on mirror
        issue(1'b1, 3'd0, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
        check("R2", "mirror ignores rs/bpos", out_data, 64'hFFFF_FFFF_FFFF_FF80 & 64'h0000_0000_0000_0080);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule